// File: doc/BRIEF.md
# Bitmap-to-Predicate Expansion Unit

The unit takes one 32-bit move-to-predicate instruction word together with a VL-bit vector operand and produces a VL/8-bit predicate. The word selects an element size of 8, 16, 32 or 64 bits and, for the wider sizes, a portion index. The unit cuts a packed bitmap out of the operand. The bitmap is one bit per element and its portion is chosen by the index. Each bitmap bit then fills the lowest bit of one predicate element, whose width is esize/8 bits. The remaining bits of that element are cleared. The source vector register number, the destination predicate register number and an undefined-encoding flag are reported with the result.

Requests enter through a valid/ready port and results leave through a second valid/ready port. A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result is presented from the next cycle. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result holds and no new request is accepted. The vector length VL is a parameter, a multiple of 128 from 128 to 2048.

Top module: `bmp2pred_unit`

## Requirements
- R1: A word is defined only if bits 31:24 are 00000101, bits 15:10 are 001110, bit 4 is 0, and bits 23:16 match exactly one form of R2–R5. Any other word sets `out_undef`.
- R2: Byte form, bits 23:16 = 00101010: predicate bit e equals operand bit e for every e below VL/8.
- R3: Halfword form, bits 23:22 = 00, 21:18 = 1011, 16 = 0, index i = bit 17: predicate bit 2e equals operand bit (VL/16)·i + e, and bit 2e+1 is 0.
- R4: Word form, bits 23:22 = 01, 21:19 = 101, 16 = 0, index i = bits 18:17: predicate bit 4e equals operand bit (VL/32)·i + e, and the other three bits of each element are 0.
- R5: Doubleword form, bit 23 = 1, 21:19 = 101, 16 = 0, index i = {bit 22, bits 18:17}: predicate bit 8e equals operand bit (VL/64)·i + e, and the other seven bits of each element are 0.
- R6: For an undefined word, `out_pred` is all zero and `out_pred_we` is low. For a defined word, `out_pred_we` is high while `out_valid` is high.
- R7: `out_zn` carries instruction bits 9:5 and `out_pd` carries bits 3:0, for defined and undefined words alike.
- R8: `in_ready` = !`out_valid` | `out_ready`. An accepted request shows on the output on the next cycle, results leave in request order, and a stalled result holds stable.
- R9: A synchronous active-high `rst` clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_instr | input | 32 | Instruction word |
| in_operand | input | VL | Source vector operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_pred | output | VL/8 | Predicate result |
| out_zn | output | 5 | Source vector register number |
| out_pd | output | 4 | Destination predicate register number |
| out_undef | output | 1 | Instruction word is undefined |
| out_pred_we | output | 1 | Destination write enable |

## Verification
The bench sweeps every element size at every legal portion index and compares each result with a model of the bit-selection rule. A design that mis-scales the bitmap base would read the wrong operand slice at higher indices. A design that spreads bits on the wrong stride would set padding bits. The bench flips each fixed-pattern bit of a valid word and also feeds random size fields, so a decoder that ignores a fixed bit, or that confuses the halfword and byte patterns, would miss `out_undef` or write a non-zero predicate. Random back-pressure on `out_ready` shows up any result that is dropped, duplicated or changed while stalled, because each such fault reorders or alters the scoreboard stream.

// File: rtl/bmp2pred_pkg.sv
package bmp2pred_pkg;
  localparam int INSTR_W = 32;
  localparam int ZN_W    = 5;
  localparam int PD_W    = 4;
  localparam int IDX_W   = 3;
  localparam int NSIZES  = 4;

  typedef enum logic [1:0] {
    ESZ_B = 2'd0,
    ESZ_H = 2'd1,
    ESZ_W = 2'd2,
    ESZ_D = 2'd3
  } esz_t;

  typedef struct packed {
    logic             undef;
    esz_t             esz;
    logic [IDX_W-1:0] idx;
    logic [ZN_W-1:0]  zn;
    logic [PD_W-1:0]  pd;
  } dec_t;
endpackage

// File: rtl/bmp2pred_decode.sv
module bmp2pred_decode
  import bmp2pred_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);
  logic common_ok;
  logic m_b, m_h, m_w, m_d;

  always_comb begin
    common_ok = (instr[31:24] == 8'b0000_0101) &&
                (instr[15:10] == 6'b001110) && !instr[4];
    m_b = (instr[23:16] == 8'b0010_1010);
    m_h = (instr[23:22] == 2'b00) && (instr[21:18] == 4'b1011) && !instr[16];
    m_w = (instr[23:22] == 2'b01) && (instr[21:19] == 3'b101) && !instr[16];
    m_d = instr[23] && (instr[21:19] == 3'b101) && !instr[16];
  end

  always_comb begin
    dec.zn    = instr[9:5];
    dec.pd    = instr[3:0];
    dec.esz   = ESZ_B;
    dec.idx   = '0;
    dec.undef = 1'b1;
    if (common_ok) begin
      if (m_b) begin
        dec.esz   = ESZ_B;
        dec.undef = 1'b0;
      end else if (m_h) begin
        dec.esz   = ESZ_H;
        dec.idx   = {2'b00, instr[17]};
        dec.undef = 1'b0;
      end else if (m_w) begin
        dec.esz   = ESZ_W;
        dec.idx   = {1'b0, instr[18:17]};
        dec.undef = 1'b0;
      end else if (m_d) begin
        dec.esz   = ESZ_D;
        dec.idx   = {instr[22], instr[18:17]};
        dec.undef = 1'b0;
      end
    end
  end

  // R1: the four form patterns never overlap
  always_comb begin
    assert_onehot_form_R1: assert ($onehot0({m_b, m_h, m_w, m_d}));
  end
endmodule

// File: rtl/bmp2pred_expand.sv
module bmp2pred_expand
  import bmp2pred_pkg::*;
#(
  parameter int VL = 256,
  localparam int PL = VL / 8
) (
  input  logic [VL-1:0]    operand,
  input  esz_t             esz,
  input  logic [IDX_W-1:0] idx,
  input  logic             undef,
  output logic [PL-1:0]    pred
);
  logic [PL-1:0] cand [NSIZES];

  for (genvar s = 0; s < NSIZES; s++) begin : g_sz
    localparam int PSZ   = 1 << s;
    localparam int ELEMS = PL / PSZ;
    logic [ELEMS-1:0] bmp;
    logic [PL-1:0]    spread;

    always_comb begin
      int base;
      base = int'(idx) & (PSZ - 1);
      bmp  = operand[base*ELEMS +: ELEMS];
    end

    for (genvar e = 0; e < ELEMS; e++) begin : g_el
      assign spread[e*PSZ] = bmp[e];
      if (PSZ > 1) begin : g_pad
        assign spread[e*PSZ+1 +: PSZ-1] = '0;
      end
    end

    assign cand[s] = spread;
  end

  assign pred = undef ? '0 : cand[esz];
endmodule

// File: rtl/bmp2pred_unit.sv
module bmp2pred_unit
  import bmp2pred_pkg::*;
#(
  parameter int VL = 256,
  localparam int PL = VL / 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [INSTR_W-1:0] in_instr,
  input  logic [VL-1:0]      in_operand,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [PL-1:0]      out_pred,
  output logic [ZN_W-1:0]    out_zn,
  output logic [PD_W-1:0]    out_pd,
  output logic               out_undef,
  output logic               out_pred_we
);
  dec_t          dec;
  logic [PL-1:0] pred_d;
  logic          valid_q;
  logic [PL-1:0] pred_q;
  logic [ZN_W-1:0] zn_q;
  logic [PD_W-1:0] pd_q;
  logic          undef_q;
  esz_t          esz_q;
  logic          take;

  bmp2pred_decode u_dec (
    .instr (in_instr),
    .dec   (dec)
  );

  bmp2pred_expand #(.VL(VL)) u_exp (
    .operand (in_operand),
    .esz     (dec.esz),
    .idx     (dec.idx),
    .undef   (dec.undef),
    .pred    (pred_d)
  );

  assign in_ready = !valid_q || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      pred_q  <= '0;
      zn_q    <= '0;
      pd_q    <= '0;
      undef_q <= 1'b0;
      esz_q   <= ESZ_B;
    end else begin
      if (in_ready) valid_q <= in_valid;
      if (take) begin
        pred_q  <= pred_d;
        zn_q    <= dec.zn;
        pd_q    <= dec.pd;
        undef_q <= dec.undef;
        esz_q   <= dec.esz;
      end
    end
  end

  assign out_valid   = valid_q;
  assign out_pred    = pred_q;
  assign out_zn      = zn_q;
  assign out_pd      = pd_q;
  assign out_undef   = undef_q;
  assign out_pred_we = valid_q && !undef_q;

  function automatic logic [PL-1:0] pad_mask(esz_t sz);
    logic [PL-1:0] m;
    int psz;
    psz = 1 << int'(sz);
    for (int k = 0; k < PL; k++) m[k] = (k % psz) != 0;
    return m;
  endfunction

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_pred) &&
      $stable(out_zn) && $stable(out_pd) && $stable(out_undef));

  assert_accept_shows_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  assert_undef_zero_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_undef |-> (out_pred == '0) && !out_pred_we);

  // R3 R4 R5: padding bits inside each wide element stay clear
  assert_pad_zero_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_pred & pad_mask(esz_q)) == '0);

  assert_reset_clear_R9: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);
endmodule

// File: tb/bmp2pred_unit_tb.sv
module bmp2pred_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int VL = 256;
  localparam int PL = VL / 8;
  localparam int WATCHDOG = 20000;

  typedef struct {
    logic [PL-1:0] pred;
    logic [4:0]    zn;
    logic [3:0]    pd;
    logic          undef;
    string         tag;
  } exp_t;

  logic clk = 0;
  logic rst = 1;
  logic in_valid = 0;
  logic in_ready;
  logic [31:0] in_instr = '0;
  logic [VL-1:0] in_operand = '0;
  logic out_valid;
  logic out_ready = 1;
  logic [PL-1:0] out_pred;
  logic [4:0] out_zn;
  logic [3:0] out_pd;
  logic out_undef;
  logic out_pred_we;

  int checks = 0;
  int fails = 0;
  int bp_mode = 0;
  bit done = 0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bmp2pred_unit #(.VL(VL)) u_dut (
    .clk, .rst, .in_valid, .in_ready, .in_instr, .in_operand,
    .out_valid, .out_ready, .out_pred, .out_zn, .out_pd,
    .out_undef, .out_pred_we
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [PL-1:0] act, input logic [PL-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference model built from the requirements
  function automatic exp_t model(input logic [31:0] w, input logic [VL-1:0] op);
    exp_t r;
    int sz;
    int idx;
    bit ok;
    r.pred = '0; r.zn = w[9:5]; r.pd = w[3:0];
    ok = (w[31:24] == 8'h05) && (w[15:10] == 6'b001110) && (w[4] == 1'b0);
    sz = -1; idx = 0;
    if (ok) begin
      if (w[23:16] == 8'h2A) begin sz = 0; idx = 0; end
      else if (w[23:22] == 2'b00 && w[21:18] == 4'b1011 && !w[16]) begin sz = 1; idx = int'(w[17]); end
      else if (w[23:22] == 2'b01 && w[21:19] == 3'b101 && !w[16]) begin sz = 2; idx = int'(w[18:17]); end
      else if (w[23] && w[21:19] == 3'b101 && !w[16]) begin sz = 3; idx = int'({w[22], w[18:17]}); end
    end
    r.undef = (sz < 0);
    case (sz)
      0: r.tag = "R2";
      1: r.tag = "R3";
      2: r.tag = "R4";
      3: r.tag = "R5";
      default: r.tag = "R1";
    endcase
    if (sz >= 0) begin
      int psz;
      int el;
      psz = 1 << sz;
      el = PL / psz;
      for (int e = 0; e < el; e++) r.pred[e*psz] = op[el*idx + e];
    end
    return r;
  endfunction

  function automatic logic [VL-1:0] rnd_op();
    logic [VL-1:0] v;
    for (int k = 0; k < VL/32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [31:0] mk(input int sz, input int idx, input logic [4:0] zn, input logic [3:0] pd);
    logic [31:0] w;
    logic [2:0] i;
    i = 3'(idx);
    w = 32'h0500_3800 | {22'd0, zn, 1'b0, pd};
    case (sz)
      0: w[23:16] = 8'h2A;
      1: w[23:16] = 8'h2C | {6'd0, i[0], 1'b0};
      2: w[23:16] = 8'h68 | {5'd0, i[1:0], 1'b0};
      default: w[23:16] = 8'hA8 | {1'b0, i[2], 3'd0, i[1:0], 1'b0};
    endcase
    return w;
  endfunction

  task automatic send(input logic [31:0] w, input logic [VL-1:0] op);
    @(negedge clk);
    in_valid = 1; in_instr = w; in_operand = op;
    while (1) begin
      #2;
      if (in_ready) break;
      @(negedge clk);
    end
    sb.push_back(model(w, op));
    @(posedge clk);
    #1 in_valid = 0;
  endtask

  // Monitor / scoreboard
  always begin
    @(negedge clk);
    case (bp_mode)
      0: out_ready = 1;
      1: out_ready = ($urandom % 3) != 0;
      default: out_ready = ($urandom % 4) == 0;
    endcase
    #1;
    if (!rst && out_valid && out_ready) begin
      if (sb.size() == 0) begin
        chk(0, "R8", "unexpected result", out_pred, '0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(out_pred == e.pred, e.tag, "predicate", out_pred, e.pred);
        chk(out_undef == e.undef, "R1", "undef flag", PL'(out_undef), PL'(e.undef));
        chk(out_pred_we == !e.undef, "R6", "write enable", PL'(out_pred_we), PL'(!e.undef));
        chk(out_zn == e.zn && out_pd == e.pd, "R7", "register numbers",
            PL'({out_zn, out_pd}), PL'({e.zn, e.pd}));
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R8 watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 0, "R9", "out_valid in reset", PL'(out_valid), '0);
    @(negedge clk) rst = 0;
    #2;
    chk(in_ready == 1, "R8", "ready after reset", PL'(in_ready), PL'(1));

    // Every size at every legal index, several operand patterns
    for (int mode = 0; mode < 3; mode++) begin
      bp_mode = mode;
      for (int sz = 0; sz < 4; sz++) begin
        for (int i = 0; i < (1 << sz); i++) begin
          send(mk(sz, i, 5'($urandom), 4'($urandom)), rnd_op());
          send(mk(sz, i, 5'd31, 4'd15), {(VL/2){2'b01}});
          send(mk(sz, i, 5'd0, 4'd0), '1);
        end
      end
    end

    // R1: flip each fixed-pattern bit of valid words
    bp_mode = 1;
    for (int b = 0; b < 32; b++) begin
      if (b == 4 || (b >= 10 && b <= 15) || b >= 24) begin
        send(mk(1, 1, 5'd3, 4'd5) ^ (32'd1 << b), '1);
        send(mk(3, 5, 5'd7, 4'd9) ^ (32'd1 << b), '1);
      end
    end
    send(mk(1, 0, 5'd1, 4'd1) | 32'h0001_0000, '1);
    send(mk(2, 3, 5'd2, 4'd2) | 32'h0001_0000, '1);
    send(mk(3, 7, 5'd4, 4'd4) | 32'h0001_0000, '1);

    // Random size fields on top of valid fixed bits
    bp_mode = 2;
    for (int n = 0; n < 64; n++) begin
      logic [31:0] w;
      w = mk(0, 0, 5'($urandom), 4'($urandom));
      w[23:16] = 8'($urandom);
      send(w, rnd_op());
    end

    // Back-to-back without stalls
    bp_mode = 0;
    for (int n = 0; n < 8; n++) send(mk(n % 4, n % (1 << (n % 4)), 5'(n), 4'(n)), rnd_op());

    for (int t = 0; t < 200 && sb.size() != 0; t++) @(posedge clk);
    chk(sb.size() == 0, "R8", "results outstanding", PL'(sb.size()), '0);
    done = 1;
    finish_run();
  end
endmodule